// File: doc/BRIEF.md
# Cartridge Interrupt Timer With Deferred Reload

This block is an interrupt source that sits on the cartridge side of an 8-bit CPU bus. The CPU writes to four decoded register slots. These slots set a reload value, pick the counting source, and turn interrupts on or off. An 8-bit down-counter counts either scanline strobes or groups of four CPU cycles. When it reaches zero while interrupts are on, an active-low interrupt line is pulled after a fixed number of CPU cycles.

All logic runs on the CPU clock (M2). The scanline strobe is a one-cycle pulse that is synchronous to that clock and comes from logic outside this block. Reload is deferred. A write to the reload or mode slot marks a reload that takes effect on the following cycle and loads the reload value plus one. A counter found at zero reloads the plain reload value on the next cycle. This gives a first period one event longer than the periods that follow.

Top module: `scan_irq_timer`

## Requirements
- R1: A write is decoded from address bits 15, 14, 13 and 0 only (mask 0xE001). The masked value 0xC000 is the reload slot, 0xC001 the mode slot, 0xE000 the disable slot and 0xE001 the enable slot. Any other masked value, such as 0x8000, 0x8001, 0xA001 or 0x6000, has no effect.
- R2: A reload-slot write stores the data byte with bit 0 forced to 0, so an odd value v behaves exactly as v-1.
- R3: On the cycle after a reload-slot or mode-slot write, the counter loads reload+1. The next IRQ then needs reload+1 counting events.
- R4: A counter found at zero loads the reload value on the next cycle. After an IRQ, the next one needs reload events. A reload of 0 never raises a second IRQ.
- R5: In scanline mode (mode data bit 0 = 0), each strobe cycle decrements the counter by one.
- R6: In CPU mode (mode data bit 0 = 1), the counter decrements once every 4 cycles, on a 2-bit prescaler that a mode write restarts. With interrupts on, the first IRQ falls 4*reload+8 cycles after the mode-write edge. Scanline strobes are ignored in this mode.
- R7: The IRQ line goes low exactly DELAY (default 4) cycles after the edge on which a decrement reaches zero with interrupts on.
- R8: Once low, the IRQ line stays low until a disable-slot or enable-slot write, either of which releases it on that write edge.
- R9: A disable-slot write cancels a delayed IRQ that is still in flight. While disabled, reaching zero raises no IRQ.
- R10: A synchronous active-high reset releases IRQ, clears all registers, selects scanline mode and disables interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock (M2) |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe for this cycle |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| line_pulse | input | 1 | One-cycle scanline strobe |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A wrong counter or reload flag shows at the ports only as an IRQ that arrives early or late. The size of that shift is an exact number of strobes or prescaled periods, so it can only be seen by counting events up to the IRQ edge for both the first period and the later periods. A wrong delay line or acknowledge path shows within a few cycles of the zero crossing, as a misplaced falling edge or an IRQ that does not hold. The bench sweeps reload values across the byte range, including odd values, 0 and the top values, and uses mirrored addresses. From these it predicts each count and latency arithmetically.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

  typedef logic [7:0]  byte_t;
  typedef logic [15:0] addr_t;

  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_RELOAD,
    SLOT_MODE,
    SLOT_OFF,
    SLOT_ON
  } slot_e;

  localparam addr_t DECODE_MASK = 16'hE001;
  localparam addr_t BASE_RELOAD = 16'hC000;
  localparam addr_t BASE_MODE   = 16'hC001;
  localparam addr_t BASE_OFF    = 16'hE000;
  localparam addr_t BASE_ON     = 16'hE001;

  // Map a CPU address to one of the register slots.
  function automatic slot_e decode_slot(input addr_t a);
    addr_t m;
    m = a & DECODE_MASK;
    case (m)
      BASE_RELOAD: decode_slot = SLOT_RELOAD;
      BASE_MODE:   decode_slot = SLOT_MODE;
      BASE_OFF:    decode_slot = SLOT_OFF;
      BASE_ON:     decode_slot = SLOT_ON;
      default:     decode_slot = SLOT_NONE;
    endcase
  endfunction

  // The reload slot keeps only the even part of the written byte.
  function automatic byte_t even_part(input byte_t d);
    even_part = {d[7:1], 1'b0};
  endfunction

  // Value loaded after a reload or mode write.
  function automatic byte_t first_load(input byte_t r);
    first_load = r + 8'd1;
  endfunction

endpackage

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
  import irq_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  addr_t addr,
  input  byte_t wdata,
  output byte_t reload_val,
  output logic  mode_cpu,
  output logic  irq_en,
  output logic  reload_pend,
  output logic  presc_clr,
  output logic  ack_wr
);

  slot_e slot;
  logic  wr_reload;
  logic  wr_mode;
  logic  wr_off;
  logic  wr_on;

  always_comb begin
    slot      = wr_en ? decode_slot(addr) : SLOT_NONE;
    wr_reload = (slot == SLOT_RELOAD);
    wr_mode   = (slot == SLOT_MODE);
    wr_off    = (slot == SLOT_OFF);
    wr_on     = (slot == SLOT_ON);
    presc_clr = wr_mode;
    ack_wr    = wr_off | wr_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_val  <= '0;
      mode_cpu    <= 1'b0;
      irq_en      <= 1'b0;
      reload_pend <= 1'b0;
    end else begin
      if (wr_reload) reload_val <= even_part(wdata);
      if (wr_mode)   mode_cpu   <= wdata[0];
      if (wr_off)    irq_en     <= 1'b0;
      else if (wr_on) irq_en    <= 1'b1;
      reload_pend <= wr_reload | wr_mode;
    end
  end

endmodule

// File: rtl/irq_timer_count.sv
module irq_timer_count
  import irq_timer_pkg::*;
#(
  parameter int PRESC_W = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  mode_cpu,
  input  logic  presc_clr,
  input  logic  line_pulse,
  input  logic  reload_pend,
  input  byte_t reload_val,
  input  logic  irq_en,
  output byte_t cnt,
  output logic  tick,
  output logic  fire
);

  localparam logic [PRESC_W-1:0] PRESC_LAST = '1;

  logic [PRESC_W-1:0] presc;
  byte_t              cnt_nxt;

  always_ff @(posedge clk) begin
    if (rst || presc_clr) presc <= '0;
    else                  presc <= presc + 1'b1;
  end

  always_comb begin
    tick    = mode_cpu ? (presc == PRESC_LAST) : line_pulse;
    cnt_nxt = cnt;
    fire    = 1'b0;
    if (reload_pend) begin
      cnt_nxt = first_load(reload_val);
    end else if (cnt == 8'd0) begin
      cnt_nxt = reload_val;
    end else if (tick) begin
      cnt_nxt = cnt - 8'd1;
      fire    = (cnt_nxt == 8'd0) && irq_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

endmodule

// File: rtl/irq_timer_delay.sv
module irq_timer_delay #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic irq_en,
  input  logic ack_wr,
  output logic delay_out,
  output logic irq
);

  generate
    if (DELAY == 0) begin : g_direct
      assign delay_out = fire;
    end else begin : g_shift
      logic [DELAY-1:0] stage;
      always_ff @(posedge clk) begin
        if (rst || !irq_en) stage <= '0;
        else if (DELAY == 1) stage <= fire;
        else stage <= {stage[DELAY-2:0], fire} & {DELAY{1'b1}};
      end
      assign delay_out = stage[DELAY-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (delay_out & irq_en) | (irq & ~ack_wr);
  end

endmodule

// File: rtl/scan_irq_timer.sv
module scan_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int PRESC_W = 2,
  parameter int DELAY   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        line_pulse,
  output logic        irq_n
);

  byte_t reload_val;
  logic  mode_cpu;
  logic  irq_en;
  logic  reload_pend;
  logic  presc_clr;
  logic  ack_wr;
  byte_t cnt;
  logic  tick;
  logic  fire;
  logic  delay_out;
  logic  irq;

  irq_timer_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .reload_val  (reload_val),
    .mode_cpu    (mode_cpu),
    .irq_en      (irq_en),
    .reload_pend (reload_pend),
    .presc_clr   (presc_clr),
    .ack_wr      (ack_wr)
  );

  irq_timer_count #(.PRESC_W(PRESC_W)) u_count (
    .clk         (clk),
    .rst         (rst),
    .mode_cpu    (mode_cpu),
    .presc_clr   (presc_clr),
    .line_pulse  (line_pulse),
    .reload_pend (reload_pend),
    .reload_val  (reload_val),
    .irq_en      (irq_en),
    .cnt         (cnt),
    .tick        (tick),
    .fire        (fire)
  );

  irq_timer_delay #(.DELAY(DELAY)) u_delay (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .irq_en    (irq_en),
    .ack_wr    (ack_wr),
    .delay_out (delay_out),
    .irq       (irq)
  );

  assign irq_n = ~irq;

endmodule

// File: rtl/scan_irq_timer_chk.sv
module scan_irq_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] reload_val,
  input logic       irq_en,
  input logic       reload_pend,
  input logic       ack_wr,
  input logic [7:0] cnt,
  input logic       tick,
  input logic       fire,
  input logic       delay_out,
  input logic       irq_n
);

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (rst)
    reload_pend |=> cnt == $past(reload_val) + 8'd1); // R3

  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!reload_pend && cnt == 8'd0) |=> cnt == $past(reload_val)); // R4

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload_pend && cnt != 8'd0) |=> cnt == $past(cnt) - 8'd1); // R5

  AST_FIRE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    fire |=> cnt == 8'd0); // R7

  AST_FALL_FROM_DELAY: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(delay_out) && $past(irq_en)); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !ack_wr) |=> !irq_n); // R8

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && !delay_out) |=> irq_n); // R8

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && $past(!irq_en)) |-> !delay_out); // R9

endmodule

bind scan_irq_timer scan_irq_timer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .reload_val  (reload_val),
  .irq_en      (irq_en),
  .reload_pend (reload_pend),
  .ack_wr      (ack_wr),
  .cnt         (cnt),
  .tick        (tick),
  .fire        (fire),
  .delay_out   (delay_out),
  .irq_n       (irq_n)
);

// File: tb/sim_scan_irq_timer.sv
module sim_scan_irq_timer;

  localparam int DLY = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        line_pulse = 1'b0;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  scan_irq_timer #(.PRESC_W(2), .DELAY(DLY)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .line_pulse(line_pulse), .irq_n(irq_n)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; line_pulse = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One strobe; lat = cycles after the strobe edge until irq_n low (0 = none in 6).
  task automatic strobe(output int lat);
    lat = 0;
    @(negedge clk); line_pulse = 1'b1;
    @(negedge clk); line_pulse = 1'b0;
    for (int d = 1; d <= 6; d++) begin
      @(negedge clk);
      if (!irq_n && lat == 0) lat = d;
    end
  endtask

  task automatic run_until_irq(input int maxp, output int np, output int lat);
    np = 0; lat = 0;
    for (int i = 0; i < maxp; i++) begin
      strobe(lat);
      np = np + 1;
      if (lat != 0) break;
    end
    if (lat == 0) np = 0;
  endtask

  initial begin
    int np, lat, r, n, first;
    logic [7:0] vals [9];
    logic [15:0] rl_addr [3];
    logic [15:0] on_addr [3];
    vals = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h10, 8'h2F, 8'h80, 8'hFE, 8'hFF};
    rl_addr = '{16'hC000, 16'hDF10, 16'hC0FE};
    on_addr = '{16'hE001, 16'hFFFF, 16'hE0F1};

    do_reset();
    check("R10 reset irq_n", irq_n, 1);

    // Scanline sweep across reload values with mirrored slots.
    for (int k = 0; k < 9; k++) begin
      do_reset();
      r = (vals[k] >> 1) << 1;
      wr(rl_addr[k % 3], vals[k]);
      wr(16'h8000, 8'h00);
      wr(16'hA001, 8'h01);
      wr(16'h6000, 8'h00);
      wr(16'hC001, 8'h00);
      wr(on_addr[k % 3], 8'h00);
      check("R10 idle before strobes", irq_n, 1);
      run_until_irq(300, np, lat);
      check("R3 R2 R1 R5 first period strobes", np, r + 1);
      check("R7 latency first", lat, DLY);
      idle(10);
      check("R8 hold low", irq_n, 0);
      wr(16'hE001, 8'h00);
      check("R8 enable-slot release", irq_n, 1);
      if (r != 0) begin
        run_until_irq(300, np, lat);
        check("R4 later period strobes", np, r);
        check("R7 latency later", lat, DLY);
        wr(16'hE000, 8'h00);
        check("R8 disable-slot release", irq_n, 1);
      end else begin
        run_until_irq(4, np, lat);
        check("R4 zero reload no second irq", np, 0);
      end
    end

    // R9: cancel in flight.
    do_reset();
    wr(16'hC000, 8'h02); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
    strobe(lat); strobe(lat);
    @(negedge clk); line_pulse = 1'b1;
    @(negedge clk); line_pulse = 1'b0;
    wr(16'hE000, 8'h00);
    idle(10);
    check("R9 cancelled irq", irq_n, 1);

    // R9: disabled counting raises nothing.
    do_reset();
    wr(16'hC000, 8'h04); wr(16'hC001, 8'h00); wr(16'hE000, 8'h00);
    run_until_irq(12, np, lat);
    check("R9 disabled no irq", np, 0);

    // R10: reset releases an asserted IRQ.
    do_reset();
    wr(16'hC000, 8'h00); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
    run_until_irq(3, np, lat);
    check("R10 irq raised before reset", np, 1);
    do_reset();
    check("R10 reset releases", irq_n, 1);

    // R6: CPU-cycle mode, with and without strobes held high.
    for (int k = 0; k < 4; k++) begin
      do_reset();
      r = 2 * (k % 2) + 2;
      wr(16'hE001, 8'h00);
      wr(16'hC000, r[7:0]);
      @(negedge clk); wr_en = 1'b1; addr = 16'hC001; wdata = 8'h01;
      if (k >= 2) line_pulse = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      n = 0; first = 0;
      for (int c = 1; c <= 4 * r + 20; c++) begin
        @(negedge clk);
        if (!irq_n && first == 0) first = c;
      end
      line_pulse = 1'b0;
      check("R6 cpu mode first irq cycle", first, 4 * r + 8);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule